// File: doc/BRIEF.md
# Multiprocessor Interrupt Broadcast Controller

This block sits next to the interrupt controller of a small multi-CPU cluster and provides three word-wide registers on a plain register bus: a system status word, a broadcast selection word and an error-mode word. The status word reports how many CPUs the system has, whether broadcasting is possible, which interrupt line carries extended interrupts, and which CPUs are powered down. Software releases a powered-down CPU by writing a one to its status bit. The same kind of write to the error-mode word forces a CPU into error mode. Each of these writes produces a one-cycle pulse toward the CPU.

Each incoming interrupt line is steered one of two ways. If its broadcast selection bit is clear, it sets the shared pending register. If the bit is set, it sets the matching bit in the force register of every CPU. The pending and force registers hold their bits until a clear input drops them. The pending register has a single clear. Each force register has a clear of its own.

When reset ends, the power-down field comes up with every CPU held except CPU 0. CPU 0 is also held if the boot-hold pin is high during reset.

Top module: `mp_irq_bcast_ctrl`

## Requirements
- R1: A read of offset 0x010 returns CPU count minus one in bits 31:28. Bit 27 is 1 exactly when that count field is nonzero. Bits 19:16 return the configured extended interrupt line, or 0 when none is configured. All other bits above bit NCPU-1 read 0.
- R2: After reset, power-down bits 1..NCPU-1 read 1. Bit 0 reads the value the boot-hold pin had during reset, so the field is 0xE with the pin low and 0xF with it high (four CPUs).
- R3: A write to offset 0x010 with bit n set gives a one-cycle pulse on start_o[n] in the next cycle and clears power-down bit n. Writing 0 to a bit has no effect on that bit or its pulse. Writes to reserved status bits are ignored.
- R4: A pulse on pwrdn_i[n] sets power-down bit n. If it arrives in the same cycle as a start write to bit n, the bit ends up set, and the start pulse is still issued.
- R5: Offset 0x014 stores bits 15:1 as broadcast mask bits. Bit 0 and bits 31:16 always read 0.
- R6: A request on irq_i[k] (k from 1 to 15) with mask bit k clear sets pend_o[k] in the next cycle and leaves every force bit unchanged.
- R7: A request on irq_i[k] with mask bit k set sets bit k of every CPU's force register (force_o[c*16+k]) in the next cycle and leaves pend_o unchanged.
- R8: pend_clr_i clears all pending bits, and force_clr_i[c] clears only CPU c's force register. A request arriving in the same cycle as a clear is kept.
- R9: Reading offset 0x018 returns err_mode_i in bits NCPU-1:0, with all other bits 0. Writing 1 to bit n gives a one-cycle pulse on force_err_o[n] in the next cycle. Writing 0 has no effect.
- R10: Interrupt line 0 never sets a pending or force bit. Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_hold_i | input | 1 | Sampled at reset; high keeps CPU 0 powered down |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwrdn_i | input | NCPU | Per-CPU power-down indication pulse |
| err_mode_i | input | NCPU | Per-CPU error-mode level |
| irq_i | input | NIRQ | Interrupt request pulses, line 0 unused |
| pend_clr_i | input | 1 | Clears the shared pending register |
| force_clr_i | input | NCPU | Per-CPU force register clear |
| start_o | output | NCPU | One-cycle CPU start pulses |
| force_err_o | output | NCPU | One-cycle force-error-mode pulses |
| pend_o | output | NIRQ | Shared pending register |
| force_o | output | NCPU*NIRQ | Force registers, CPU c at bits c*NIRQ+NIRQ-1 : c*NIRQ |

## Verification
The bench builds the block with four CPUs, 16 interrupt lines and extended line 5. With four CPUs the power-down field fills all four low bits, the broadcast-available bit is 1, and routing of one request into four force registers can be checked against a per-CPU clear that drops only one of them. A nonzero extended line puts a value into bits 19:16, so a fault in the status packing shows up. The bench applies reset twice, once with the boot-hold pin low and once with it high, to reach both reset values of the field.

// File: rtl/mpib_pkg.sv
`timescale 1ns/1ps
package mpib_pkg;

  localparam int unsigned WORD_W = 32;

  // register offsets (byte addressed)
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_BCAST = 8'h14;
  localparam logic [7:0] OFS_ERR   = 8'h18;

  // status word packing: count-1, broadcast flag, ext line, power-down field
  function automatic logic [WORD_W-1:0] pack_status(
    input logic [3:0] cnt_m1,
    input logic [3:0] ext_line,
    input logic [3:0] pd_field
  );
    logic bflag;
    bflag = (cnt_m1 != 4'd0);
    pack_status = {cnt_m1, bflag, 1'b0, 6'b0, ext_line, 12'b0, pd_field};
  endfunction

  // broadcast mask word: line 0 never stored
  function automatic logic [WORD_W-1:0] pack_mask(
    input logic [15:0] mask
  );
    pack_mask = {16'b0, mask[15:1], 1'b0};
  endfunction

  // reset value of the power-down field
  function automatic logic [3:0] pd_reset_value(
    input logic hold
  );
    pd_reset_value = {3'b111, hold};
  endfunction

endpackage

// File: rtl/mpib_ctl.sv
`timescale 1ns/1ps
module mpib_ctl #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned NIRQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boot_hold_i,
  input  logic            wr_stat,
  input  logic            wr_mask,
  input  logic            wr_err,
  input  logic [NIRQ-1:0] wdata_lo,
  input  logic [NCPU-1:0] pwrdn_i,
  output logic [NCPU-1:0] pd_q,
  output logic [NIRQ-1:0] mask_q,
  output logic [NCPU-1:0] start_o,
  output logic [NCPU-1:0] force_err_o,
  output logic [NCPU-1:0] start_evt,
  output logic [NCPU-1:0] ferr_evt
);
  import mpib_pkg::*;

  logic [NCPU-1:0] pd_rst;
  logic [NCPU-1:0] pd_d;
  logic [3:0]      pd_rst4;

  assign pd_rst4 = pd_reset_value(boot_hold_i);

  // events for the checker: an accepted one on a start or force-error bit
  assign start_evt = wr_stat ? wdata_lo[NCPU-1:0] : '0;
  assign ferr_evt  = wr_err  ? wdata_lo[NCPU-1:0] : '0;

  always_comb begin
    pd_rst = '1;
    pd_rst[0] = pd_rst4[0];
  end

  // per-CPU next state: power-down indication wins over a start write
  for (genvar n = 0; n < NCPU; n++) begin : g_pd
    always_comb begin
      if (pwrdn_i[n])        pd_d[n] = 1'b1;
      else if (start_evt[n]) pd_d[n] = 1'b0;
      else                   pd_d[n] = pd_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q        <= pd_rst;
      mask_q      <= '0;
      start_o     <= '0;
      force_err_o <= '0;
    end else begin
      pd_q        <= pd_d;
      start_o     <= start_evt;
      force_err_o <= ferr_evt;
      if (wr_mask) mask_q <= {wdata_lo[NIRQ-1:1], 1'b0};
    end
  end

endmodule

// File: rtl/mpib_route.sv
`timescale 1ns/1ps
module mpib_route #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned NIRQ = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ-1:0]      irq_i,
  input  logic [NIRQ-1:0]      mask_q,
  input  logic                 pend_clr_i,
  input  logic [NCPU-1:0]      force_clr_i,
  output logic [NIRQ-1:0]      pend_o,
  output logic [NCPU*NIRQ-1:0] force_o,
  output logic [NIRQ-1:0]      pend_evt,
  output logic [NIRQ-1:0]      bcast_evt
);
  logic [NIRQ-1:0] live;

  // line 0 is not a request line
  always_comb begin
    live    = irq_i;
    live[0] = 1'b0;
  end

  assign pend_evt  = live & ~mask_q;
  assign bcast_evt = live &  mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~{NIRQ{pend_clr_i}}) | pend_evt;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NIRQ-1:0] frc_q;
    always_ff @(posedge clk) begin
      if (!rst_n) frc_q <= '0;
      else        frc_q <= (frc_q & ~{NIRQ{force_clr_i[c]}}) | bcast_evt;
    end
    assign force_o[c*NIRQ +: NIRQ] = frc_q;
  end

endmodule

// File: rtl/mpib_rdmux.sv
`timescale 1ns/1ps
module mpib_rdmux #(
  parameter int unsigned NCPU    = 4,
  parameter int unsigned NIRQ    = 16,
  parameter int unsigned EXT_IRQ = 0
) (
  input  logic            sel_stat,
  input  logic            sel_mask,
  input  logic            sel_err,
  input  logic [NCPU-1:0] pd_q,
  input  logic [NIRQ-1:0] mask_q,
  input  logic [NCPU-1:0] err_mode_i,
  output logic [31:0]     rdata
);
  import mpib_pkg::*;

  localparam logic [3:0] CNT_M1 = 4'(NCPU - 1);
  localparam logic [3:0] EXT_LN = 4'(EXT_IRQ);

  logic [3:0]  pd4;
  logic [15:0] mask16;
  logic [31:0] err32;

  always_comb begin
    pd4 = '0;
    pd4[NCPU-1:0] = pd_q;
    mask16 = '0;
    mask16[NIRQ-1:0] = mask_q;
    err32 = '0;
    err32[NCPU-1:0] = err_mode_i;
  end

  always_comb begin
    unique case (1'b1)
      sel_stat: rdata = pack_status(CNT_M1, EXT_LN, pd4);
      sel_mask: rdata = pack_mask(mask16);
      sel_err:  rdata = err32;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/mp_irq_bcast_ctrl.sv
`timescale 1ns/1ps
module mp_irq_bcast_ctrl #(
  parameter int unsigned NCPU    = 4,
  parameter int unsigned NIRQ    = 16,
  parameter int unsigned EXT_IRQ = 0,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boot_hold_i,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NCPU-1:0]      pwrdn_i,
  input  logic [NCPU-1:0]      err_mode_i,
  input  logic [NIRQ-1:0]      irq_i,
  input  logic                 pend_clr_i,
  input  logic [NCPU-1:0]      force_clr_i,
  output logic [NCPU-1:0]      start_o,
  output logic [NCPU-1:0]      force_err_o,
  output logic [NIRQ-1:0]      pend_o,
  output logic [NCPU*NIRQ-1:0] force_o
);
  import mpib_pkg::*;

  logic sel_stat, sel_mask, sel_err;
  logic wr_stat, wr_mask, wr_err;
  logic [NCPU-1:0] pd_q;
  logic [NIRQ-1:0] mask_q;
  logic [NCPU-1:0] start_evt, ferr_evt;
  logic [NIRQ-1:0] pend_evt, bcast_evt;
  logic            unused_wdata;

  assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign sel_mask = (reg_addr == ADDR_W'(OFS_BCAST));
  assign sel_err  = (reg_addr == ADDR_W'(OFS_ERR));

  assign wr_stat = reg_we & sel_stat;
  assign wr_mask = reg_we & sel_mask;
  assign wr_err  = reg_we & sel_err;

  assign unused_wdata = ^reg_wdata[31:NIRQ];

  mpib_ctl #(.NCPU(NCPU), .NIRQ(NIRQ)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_hold_i (boot_hold_i),
    .wr_stat     (wr_stat),
    .wr_mask     (wr_mask),
    .wr_err      (wr_err),
    .wdata_lo    (reg_wdata[NIRQ-1:0]),
    .pwrdn_i     (pwrdn_i),
    .pd_q        (pd_q),
    .mask_q      (mask_q),
    .start_o     (start_o),
    .force_err_o (force_err_o),
    .start_evt   (start_evt),
    .ferr_evt    (ferr_evt)
  );

  mpib_route #(.NCPU(NCPU), .NIRQ(NIRQ)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq_i),
    .mask_q      (mask_q),
    .pend_clr_i  (pend_clr_i),
    .force_clr_i (force_clr_i),
    .pend_o      (pend_o),
    .force_o     (force_o),
    .pend_evt    (pend_evt),
    .bcast_evt   (bcast_evt)
  );

  mpib_rdmux #(.NCPU(NCPU), .NIRQ(NIRQ), .EXT_IRQ(EXT_IRQ)) u_rd (
    .sel_stat   (sel_stat),
    .sel_mask   (sel_mask),
    .sel_err    (sel_err),
    .pd_q       (pd_q),
    .mask_q     (mask_q),
    .err_mode_i (err_mode_i),
    .rdata      (reg_rdata)
  );

endmodule

// File: rtl/mpib_chk.sv
`timescale 1ns/1ps
module mpib_chk #(
  parameter int unsigned NCPU    = 4,
  parameter int unsigned NIRQ    = 16,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 reg_we,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [NCPU-1:0]      pwrdn_i,
  input logic [NIRQ-1:0]      irq_i,
  input logic [NCPU-1:0]      start_o,
  input logic [NCPU-1:0]      force_err_o,
  input logic [NIRQ-1:0]      pend_o,
  input logic [NCPU*NIRQ-1:0] force_o,
  input logic [NCPU-1:0]      pd_q,
  input logic [NIRQ-1:0]      mask_q
);
  import mpib_pkg::*;

  AST_STAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_STAT)) |-> (reg_rdata[31:28] == 4'(NCPU - 1))); // R1

  AST_MASK_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_BCAST)) |-> (reg_rdata[0] == 1'b0 && reg_rdata[31:16] == 16'b0)); // R5

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu_chk
    AST_START_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[n] |-> ($past(rst_n) && $past(reg_we && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[n]))); // R3

    AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && start_o[n] && !$past(pwrdn_i[n])) |-> !pd_q[n]); // R3

    AST_PD_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pwrdn_i[n])) |-> pd_q[n]); // R4

    AST_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      force_err_o[n] |-> ($past(rst_n) && $past(reg_we && reg_addr == ADDR_W'(OFS_ERR) && reg_wdata[n]))); // R9
  end

  for (genvar k = 1; k < NIRQ; k++) begin : g_line_chk
    AST_PEND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(pend_o[k])) |-> $past(irq_i[k] && !mask_q[k])); // R6

    for (genvar c = 0; c < NCPU; c++) begin : g_frc
      AST_FORCE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_i[k] && mask_q[k])) |-> force_o[c*NIRQ + k]); // R7
    end
  end

  AST_LINE0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[0]); // R10

endmodule

bind mp_irq_bcast_ctrl mpib_chk #(.NCPU(NCPU), .NIRQ(NIRQ), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .pwrdn_i     (pwrdn_i),
  .irq_i       (irq_i),
  .start_o     (start_o),
  .force_err_o (force_err_o),
  .pend_o      (pend_o),
  .force_o     (force_o),
  .pd_q        (pd_q),
  .mask_q      (mask_q)
);

// File: tb/tb_mp_irq_bcast_ctrl.sv
`timescale 1ns/1ps
module tb_mp_irq_bcast_ctrl;
  localparam int NCPU = 4;
  localparam int NIRQ = 16;
  localparam int EXTL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_hold_i = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCPU-1:0] pwrdn_i = '0;
  logic [NCPU-1:0] err_mode_i = '0;
  logic [NIRQ-1:0] irq_i = '0;
  logic pend_clr_i = 1'b0;
  logic [NCPU-1:0] force_clr_i = '0;
  logic [NCPU-1:0] start_o, force_err_o;
  logic [NIRQ-1:0] pend_o;
  logic [NCPU*NIRQ-1:0] force_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  mp_irq_bcast_ctrl #(.NCPU(NCPU), .NIRQ(NIRQ), .EXT_IRQ(EXTL), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .boot_hold_i(boot_hold_i),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwrdn_i(pwrdn_i), .err_mode_i(err_mode_i), .irq_i(irq_i),
    .pend_clr_i(pend_clr_i), .force_clr_i(force_clr_i),
    .start_o(start_o), .force_err_o(force_err_o), .pend_o(pend_o), .force_o(force_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected status word built from R1 independently
  function automatic logic [31:0] exp_stat(input logic [3:0] pd);
    logic [31:0] w;
    w = '0;
    w[31:28] = 4'(NCPU - 1);
    w[27] = (NCPU > 1);
    w[19:16] = 4'(EXTL);
    w[3:0] = pd;
    return w;
  endfunction

  function automatic logic [63:0] all_cpus(input logic [15:0] v);
    return {v, v, v, v};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_reset(input logic hold);
    rst_n = 1'b0; boot_hold_i = hold;
    step(); step();
    rst_n = 1'b1; boot_hold_i = 1'b0;
  endtask

  task automatic t_reset_and_id();
    logic [31:0] d;
    do_reset(1'b1);
    rd(8'h10, d); check("R2 hold high", d, exp_stat(4'hF));
    do_reset(1'b0);
    rd(8'h10, d); check("R2 hold low / R1 status", d, exp_stat(4'hE));
    check("R2 outputs idle", {start_o, force_err_o, pend_o}, '0);
    check("R2 force idle", force_o, '0);
  endtask

  task automatic t_start();
    logic [31:0] d;
    wr(8'h10, 32'h6);
    check("R3 start pulse", start_o, 4'h6);
    rd(8'h10, d); check("R3 status cleared", d, exp_stat(4'h8));
    step();
    check("R3 single cycle pulse", start_o, 4'h0);
    wr(8'h10, 32'hFFFF_FFF0);
    check("R3 reserved/zero write no pulse", start_o, 4'h0);
    rd(8'h10, d); check("R3 zero write no change", d, exp_stat(4'h8));
  endtask

  task automatic t_pwrdn();
    logic [31:0] d;
    pwrdn_i = 4'h2; step(); pwrdn_i = '0;
    rd(8'h10, d); check("R4 power-down sets bit", d, exp_stat(4'hA));
    reg_addr = 8'h10; reg_we = 1'b1; reg_wdata = 32'h2; pwrdn_i = 4'h2;
    step();
    reg_we = 1'b0; pwrdn_i = '0; reg_wdata = '0;
    check("R4 start pulse still given", start_o, 4'h2);
    rd(8'h10, d); check("R4 power-down wins", d, exp_stat(4'hA));
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R5 mask reserved bits", d, 32'h0000_FFFE);
    wr(8'h14, 32'h0000_0024);
    rd(8'h14, d); check("R5 mask readback", d, 32'h0000_0024);
  endtask

  task automatic t_route();
    irq_i = 16'h0028; step(); irq_i = '0;
    check("R6 unmasked to pending", pend_o, 16'h0008);
    check("R7 masked to every force reg", force_o, all_cpus(16'h0020));
    irq_i = 16'h0001; step(); irq_i = '0;
    check("R10 line 0 pending", pend_o, 16'h0008);
    check("R10 line 0 force", force_o, all_cpus(16'h0020));
  endtask

  task automatic t_clear();
    force_clr_i = 4'b0100; step(); force_clr_i = '0;
    check("R8 per-CPU force clear", force_o, {16'h0020, 16'h0000, 16'h0020, 16'h0020});
    pend_clr_i = 1'b1; irq_i = 16'h0080; step(); pend_clr_i = 1'b0; irq_i = '0;
    check("R8 clear with new request", pend_o, 16'h0080);
    force_clr_i = 4'b0001; irq_i = 16'h0004; step(); force_clr_i = '0; irq_i = '0;
    check("R8 force set beats clear", force_o, {16'h0024, 16'h0004, 16'h0024, 16'h0004});
  endtask

  task automatic t_err();
    logic [31:0] d;
    err_mode_i = 4'b1010;
    rd(8'h18, d); check("R9 error state read", d, 32'h0000_000A);
    wr(8'h18, 32'h5);
    check("R9 force-error pulse", force_err_o, 4'h5);
    step();
    check("R9 pulse ends", force_err_o, 4'h0);
    wr(8'h18, 32'h0);
    check("R9 zero write no pulse", force_err_o, 4'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(8'h1C, d); check("R10 unmapped read", d, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF);
    check("R10 unmapped write pulses", {start_o, force_err_o}, 8'h0);
    rd(8'h14, d); check("R10 unmapped write mask kept", d, 32'h0000_0024);
    rd(8'h10, d); check("R10 unmapped write status kept", d, exp_stat(4'hA));
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_id();
    t_start();
    t_pwrdn();
    t_mask();
    t_route();
    t_clear();
    t_err();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule